// File: doc/BRIEF.md
# Band-Selectable Even-Ratio Prescaler (32/34)

This block divides an input clock by either 32 or 34. The choice comes from a single band-select pin. The division is built as a chain of stages:

- a front toggle stage that halves the clock;
- a cell that counts two or three of those halves;
- a binary ripple section of three toggle stages.

Because of the front halving, both ratios are even. A qualifier register adds one extra count to the middle cell in the last ripple step of each output period when the long ratio is selected. That register only updates on ticks of the front stage, so the modulus decision is pipelined. Every stage output is brought out as a registered tap, so that an external decoder can read the position inside the period.

The design is fully synchronous to the input clock and uses stage enables in place of derived clocks. The band pin is sampled only at the edge that closes an output period, so a period is never a mix of the two ratios. Reset is synchronous. It loads the band pin directly, so the first period after reset already has the selected length.

Top module: `band_prescaler`

## Requirements
- R1: With `band_hi` = 1 the top tap `tap_o[4]` falls once every 32 input cycles.
- R2: With `band_hi` = 0 the top tap `tap_o[4]` falls once every 34 input cycles.
- R3: `tap_o[0]`, the front stage, toggles on every input clock edge outside reset.
- R4: `tap_o[1]` is low for the first front-stage tick of every middle-cell count. The middle cell counts 2 front ticks, or 3 during the last ripple step of a 34-period. `tap_o[1]` only changes on edges where `tap_o[0]` falls.
- R5: `tap_o[4:2]` is a binary count (bit 2 = LSB) of completed middle-cell counts. It steps 0 to 7 within each period, and a tap above bit 2 only changes when the tap below it falls.
- R6: `mc_o` is high for exactly the last 6 input cycles of each 34-period, and stays low throughout 32-periods. It is only high while `tap_o[4:2]` = 7.
- R7: `band_hi` is sampled only at the edge that ends an output period, which is the edge where `tap_o[4:2]` wraps from 7 to 0. A change at any other time has no effect until that edge.
- R8: Synchronous reset clears all taps and `mc_o` and loads the band. The first period after reset has the selected length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| band_hi | input | 1 | 1 selects divide-by-32, 0 selects divide-by-34 |
| tap_o | output | 5 | Registered stage outputs, bit 0 = front stage, bit 4 = last ripple stage |
| mc_o | output | 1 | Modulus-control pulse that stretches the middle cell to 3 |

## Verification
Two things can land on the same edge: the period-closing edge that samples the band pin, and the edge where the qualifier drops `mc_o` and the middle cell wraps. The bench sweeps the moment of a band flip across every phase of a period, in both directions, including the cycle just before the closing edge. At every cycle it compares each tap and `mc_o` against a phase model computed arithmetically. That model takes the new ratio only from the band value present at the closing edge, and it judges the length of each period from the falling edges of the top tap.

// File: rtl/bpre_pkg.sv
package bpre_pkg;
  localparam int unsigned DEF_RIPPLE = 3;

  // input cycles per output period for a ripple depth and a mode
  function automatic int unsigned period_len(int unsigned ripple, bit long_mode);
    return 2 * ((2 << ripple) + (long_mode ? 1 : 0));
  endfunction
endpackage

// File: rtl/bpre_front.sv
module bpre_front (
  input  logic clk,
  input  logic rst,
  output logic q,
  output logic tick
);
  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= ~q;
  end

  // high in the cycle whose closing edge ends a front-stage period
  assign tick = q;
endmodule

// File: rtl/bpre_cell23.sv
module bpre_cell23 (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  input  logic stretch,
  output logic tap,
  output logic wrap
);
  logic [1:0] cnt;
  logic [1:0] last;

  assign last = stretch ? 2'd2 : 2'd1;
  assign wrap = adv && (cnt == last);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= 2'd0;
      tap <= 1'b0;
    end else if (adv) begin
      cnt <= wrap ? 2'd0 : cnt + 2'd1;
      tap <= ~wrap;
    end
  end
endmodule

// File: rtl/bpre_ripple.sv
module bpre_ripple #(
  parameter int unsigned STAGES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  output logic [STAGES-1:0] q,
  output logic              wrap_all,
  output logic              next_full
);
  localparam logic [STAGES-1:0] FULL = {STAGES{1'b1}};
  localparam logic [STAGES-1:0] PRE  = FULL - 1'b1;

  logic [STAGES:0] carry;
  assign carry[0] = adv;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    assign carry[i+1] = carry[i] & q[i];
    always_ff @(posedge clk) begin
      if (rst)           q[i] <= 1'b0;
      else if (carry[i]) q[i] <= ~q[i];
    end
  end

  assign wrap_all  = carry[STAGES];
  assign next_full = adv ? (q == PRE) : (q == FULL);
endmodule

// File: rtl/bpre_qualifier.sv
module bpre_qualifier (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  input  logic band_hi,
  input  logic boundary,
  input  logic next_full,
  output logic mc,
  output logic sel_long
);
  always_ff @(posedge clk) begin
    if (rst)           sel_long <= ~band_hi;
    else if (boundary) sel_long <= ~band_hi;
  end

  // updated only on front-stage ticks: pipelined modulus decision
  always_ff @(posedge clk) begin
    if (rst)      mc <= 1'b0;
    else if (adv) mc <= sel_long & next_full;
  end
endmodule

// File: rtl/band_prescaler.sv
module band_prescaler #(
  parameter int unsigned RIPPLE = bpre_pkg::DEF_RIPPLE
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            band_hi,
  output logic [RIPPLE+1:0] tap_o,
  output logic            mc_o
);
  logic              q_front, tick_front;
  logic              tap_mid, wrap_mid;
  logic [RIPPLE-1:0] q_rip;
  logic              boundary, next_full;
  logic              mc, sel_long;

  bpre_front u_front (
    .clk(clk), .rst(rst), .q(q_front), .tick(tick_front)
  );

  bpre_cell23 u_mid (
    .clk(clk), .rst(rst), .adv(tick_front), .stretch(mc),
    .tap(tap_mid), .wrap(wrap_mid)
  );

  bpre_ripple #(.STAGES(RIPPLE)) u_rip (
    .clk(clk), .rst(rst), .adv(wrap_mid), .q(q_rip),
    .wrap_all(boundary), .next_full(next_full)
  );

  bpre_qualifier u_qual (
    .clk(clk), .rst(rst), .adv(tick_front), .band_hi(band_hi),
    .boundary(boundary), .next_full(next_full),
    .mc(mc), .sel_long(sel_long)
  );

  assign tap_o = {q_rip, tap_mid, q_front};
  assign mc_o  = mc;
endmodule

// File: rtl/bpre_checker.sv
module bpre_checker #(
  parameter int unsigned RIPPLE = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [RIPPLE+1:0] tap,
  input logic              mc,
  input logic              sel_long
);
  localparam int unsigned TW = RIPPLE + 2;

  a_r3_front_toggles: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (tap[0] != $past(tap[0])));

  a_r4_mid_on_front_fall: assert property (@(posedge clk) disable iff (rst)
    $changed(tap[1]) |-> $fell(tap[0]));

  for (genvar i = 3; i < TW; i++) begin : g_rip
    a_r5_ripple_carry: assert property (@(posedge clk) disable iff (rst)
      $changed(tap[i]) |-> $fell(tap[i-1]));
  end

  a_r6_mc_in_last_step: assert property (@(posedge clk) disable iff (rst)
    mc |-> (&tap[TW-1:2]));

  a_r6_mc_ends_at_wrap: assert property (@(posedge clk) disable iff (rst)
    $fell(mc) |-> (tap[TW-1:2] == '0));

  a_r7_band_only_at_wrap: assert property (@(posedge clk) disable iff (rst)
    $changed(sel_long) |-> ($past(&tap[TW-1:2]) && (tap[TW-1:2] == '0)));
endmodule

bind band_prescaler bpre_checker #(.RIPPLE(RIPPLE)) u_chk (
  .clk(clk), .rst(rst), .tap(tap_o), .mc(mc_o), .sel_long(sel_long)
);

// File: tb/test_band_prescaler.sv
module test_band_prescaler;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       band_hi = 1'b1;
  logic [4:0] tap_o;
  logic       mc_o;

  int checks = 0;
  int fails  = 0;
  int cyc = 0;
  int p = 0;
  int ratio = 32;
  int prev_ratio = 32;
  int last_fall = 0;
  bit prev_top = 1'b0;
  bit first_after_rst = 1'b1;
  bit done = 1'b0;

  band_prescaler i_band_prescaler (
    .clk(clk), .rst(rst), .band_hi(band_hi), .tap_o(tap_o), .mc_o(mc_o)
  );

  always #10 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s cyc=%0d phase=%0d act=%0d exp=%0d", tag, cyc, p, act, exp);
    end
  endtask

  task automatic compare_model();
    int r, loc, c2;
    r   = (p / 4 > 7) ? 7 : p / 4;
    loc = p - 4 * r;
    c2  = loc / 2;
    chk("R3 front tap", tap_o[0], p % 2);
    chk("R4 middle tap", tap_o[1], (c2 != 0) ? 1 : 0);
    chk("R5 ripple taps", tap_o[4:2], r);
    chk("R6 mc", mc_o, (ratio == 34 && p >= 28) ? 1 : 0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    p = 0;
    ratio = band_hi ? 32 : 34;
    last_fall = cyc;
    prev_top = 1'b0;
    first_after_rst = 1'b1;
    chk("R8 reset taps", tap_o, 0);
    chk("R8 reset mc", mc_o, 0);
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    p++;
    if (p == ratio) begin
      p = 0;
      prev_ratio = ratio;
      ratio = band_hi ? 32 : 34;  // band seen at the closing edge (R7)
    end
    compare_model();
    if (prev_top && !tap_o[4]) begin
      if (first_after_rst) chk("R8 first period", cyc - last_fall, prev_ratio);
      else if (prev_ratio == 32) chk("R1 period length", cyc - last_fall, 32);
      else chk("R2 period length", cyc - last_fall, 34);
      first_after_rst = 1'b0;
      last_fall = cyc;
    end
    prev_top = tap_o[4];
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R8 + R1: reset with band high, several short periods
    band_hi = 1'b1;
    do_reset();
    repeat (130) step();
    // R7: flip band at every phase, both directions, then run on
    for (int dir = 0; dir < 2; dir++) begin
      for (int k = 0; k < 34; k++) begin
        while (p != (k % ratio)) step();
        band_hi = ~band_hi;
        repeat (75) step();
      end
    end
    // R8 + R2: reset mid-run with band low
    repeat (11) step();
    band_hi = 1'b0;
    do_reset();
    repeat (140) step();
    // R8: reset mid-run back to band high
    repeat (7) step();
    band_hi = 1'b1;
    do_reset();
    repeat (100) step();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule